// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits beside a receive MAC and decides, for each incoming frame, whether the frame is kept or dropped. The MAC presents the 48-bit destination address together with a one-cycle strobe. Exactly one cycle later the filter returns a single accept flag. The filter works out the frame class from the address itself: broadcast, multicast or unicast. It then applies a small control register, an enable bit for the one address entry, and the programmed station address held in that entry.

The station address entry is loaded from a parameter at reset and can be rewritten through a small register port. The control word has a separate accept bit for each frame class. It also has a compare-enable bit and a complement bit. With the complement bit set, unicast matching is inverted, so the filter keeps frames that are not addressed to the station. The register port also reads back, so software can confirm what it programmed. Only one address entry exists; the enable bits for any further entries are dropped on write.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the control register and the enable register read 0. The upper entry word reads station bytes 0..3 with byte 0 in bits 31:24. The lower entry word reads bytes 4 and 5 in bits 31:16, with bits 15:0 zero.
- R2: The enable register (select 1) keeps only bit 0, the enable for entry 0. Bits 31:1 are dropped on write and always read 0.
- R3: The frame class comes from dst_addr, where byte 0 (the first byte on the wire) is dst_addr[47:40]. An address of all ones is broadcast. Any other address with dst_addr[40] set is multicast. Every remaining address is unicast.
- R4: A unicast frame is accepted whenever the accept-all-unicast bit (control bit 0) is set.
- R5: Without bit 0 or bit 4 set, a unicast frame is accepted only when three conditions hold: compare-enable (control bit 3) is set, enable bit 0 is set, and dst_addr equals the 48-bit entry.
- R6: With the complement bit (control bit 4) set and bit 0 clear, a unicast frame is accepted exactly when the R5 match condition is false.
- R7: With bit 4 clear, a broadcast frame is accepted only if control bit 2 is set. A multicast frame is accepted only if control bit 1 is set.
- R8: With bit 4 set, broadcast and multicast frames are accepted regardless of bits 1 and 2.
- R9: out_valid is high exactly in the cycle after an in_valid cycle. That cycle's out_accept gives the decision for the strobed address, using the configuration in place at the strobe. out_accept is 0 whenever out_valid is 0.
- R10: The register port decodes a select field: 0 is control, 1 is enable, 2 is the upper entry word, 3 is the lower entry word. A write lands at the clock edge. Control bits 31:5 and lower-word bits 15:0 are dropped and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for read-back |
| rd_data | output | 32 | Read-back data (combinational) |
| in_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first byte in bits 47:40 |
| out_valid | output | 1 | Decision valid, one cycle after in_valid |
| out_accept | output | 1 | Accept flag for the strobed frame |

## Verification
The bench sends the all-ones address with only the multicast bit enabled. A design that treated broadcast as a kind of multicast would accept that frame. Addresses that differ from the entry only in the last byte would be let through by a compare that checks only part of the entry. Addresses with the group bit set in the first byte catch a design that reads the byte order backwards. In complement mode the bench checks matching and non-matching unicast as well as group frames, which exposes a missing inversion or an inversion applied to the wrong class. Back-to-back strobes under changing accept bits show whether a decision slips by a cycle or uses the wrong cycle's configuration.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned MAC_W  = 48;

   typedef enum logic [1:0] {
      FC_UCAST = 2'd0,
      FC_MCAST = 2'd1,
      FC_BCAST = 2'd2
   } frame_class_e;

   typedef struct packed {
      logic inv_cmp;    // bit 4
      logic cmp_en;     // bit 3
      logic take_bc;    // bit 2
      logic take_mc;    // bit 1
      logic take_uc;    // bit 0
   } filt_ctrl_t;

   localparam int unsigned CTRL_W = $bits(filt_ctrl_t);

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_EN   = 2'd1;
   localparam logic [1:0] SEL_HI   = 2'd2;
   localparam logic [1:0] SEL_LO   = 2'd3;
endpackage

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs
   import rxaf_pkg::*;
#(
   parameter logic [MAC_W-1:0] STATION_MAC = 48'h02_11_22_33_44_55,
   parameter int unsigned      SEL_W       = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_data,
   output filt_ctrl_t        ctrl,
   output logic              ent_en,
   output logic [MAC_W-1:0]  ent_addr
);
   localparam int unsigned HI_W = WORD_W;
   localparam int unsigned LO_W = MAC_W - WORD_W;

   if (SEL_W != 2) begin : g_bad_sel
      $error("rxaf_cfg_regs: SEL_W must be 2");
   end
   if (MAC_W <= WORD_W) begin : g_bad_split
      $error("rxaf_cfg_regs: address must span two words");
   end

   filt_ctrl_t      ctrl_q;
   logic            en_q;
   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= 1'b0;
         hi_q   <= STATION_MAC[MAC_W-1 -: HI_W];
         lo_q   <= STATION_MAC[LO_W-1:0];
      end else if (wr_en) begin
         case (wr_sel)
            SEL_CTRL: ctrl_q <= filt_ctrl_t'(wr_data[CTRL_W-1:0]);
            SEL_EN:   en_q   <= wr_data[0];
            SEL_HI:   hi_q   <= wr_data;
            default:  lo_q   <= wr_data[WORD_W-1 -: LO_W];
         endcase
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_CTRL: rd_data = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
         SEL_EN:   rd_data = {{(WORD_W-1){1'b0}}, en_q};
         SEL_HI:   rd_data = hi_q;
         default:  rd_data = {lo_q, {(WORD_W-LO_W){1'b0}}};
      endcase
   end

   assign ctrl     = ctrl_q;
   assign ent_en   = en_q;
   assign ent_addr = {hi_q, lo_q};

   AST_EN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_sel == SEL_EN |=> ent_en == $past(wr_data[0])); // R2
endmodule

// File: rtl/rxaf_class_decode.sv
module rxaf_class_decode
   import rxaf_pkg::*;
#(
   parameter int unsigned ADDR_W = MAC_W
)(
   input  logic [ADDR_W-1:0] addr,
   output frame_class_e      cls
);
   localparam int unsigned GROUP_BIT = ADDR_W - 8;

   if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_w
      $error("rxaf_class_decode: ADDR_W must be whole bytes");
   end

   always_comb begin
      if (&addr)                 cls = FC_BCAST;
      else if (addr[GROUP_BIT])  cls = FC_MCAST;
      else                       cls = FC_UCAST;
   end
endmodule

// File: rtl/rxaf_addr_match.sv
module rxaf_addr_match #(
   parameter int unsigned ADDR_W = 48
)(
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   output logic              equal
);
   localparam int unsigned NBYTES = ADDR_W / 8;

   if (ADDR_W % 8 != 0) begin : g_bad_w
      $error("rxaf_addr_match: ADDR_W must be whole bytes");
   end

   logic [NBYTES-1:0] byte_eq;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign byte_eq[g] = (a[g*8 +: 8] == b[g*8 +: 8]);
   end

   assign equal = &byte_eq;
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
   import rxaf_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  frame_class_e cls,
   input  logic         addr_eq,
   input  filt_ctrl_t   ctrl,
   input  logic         ent_en,
   output logic         out_valid,
   output logic         out_accept
);
   logic hit;
   logic take;

   always_comb begin
      hit = ctrl.cmp_en & ent_en & addr_eq;
      case (cls)
         FC_BCAST: take = ctrl.inv_cmp | ctrl.take_bc;
         FC_MCAST: take = ctrl.inv_cmp | ctrl.take_mc;
         default:  take = ctrl.take_uc | (ctrl.inv_cmp ? ~hit : hit);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_accept <= 1'b0;
      end else begin
         out_valid  <= in_valid;
         out_accept <= in_valid & take;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9
   AST_VALID_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R9
   AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_accept); // R9
   AST_UCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cls == FC_UCAST && ctrl.take_uc |=> out_accept); // R4
   AST_BCAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cls == FC_BCAST && !ctrl.inv_cmp && !ctrl.take_bc |=> !out_accept); // R7
   AST_GROUP_INV: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cls != FC_UCAST && ctrl.inv_cmp |=> out_accept); // R8
   AST_UCAST_NOCMP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cls == FC_UCAST && !ctrl.take_uc && !ctrl.inv_cmp && !ctrl.cmp_en
      |=> !out_accept); // R5
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxaf_pkg::*;
#(
   parameter logic [47:0] STATION_MAC = 48'h02_11_22_33_44_55
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [31:0] wr_data,
   input  logic [1:0]  rd_sel,
   output logic [31:0] rd_data,
   input  logic        in_valid,
   input  logic [47:0] dst_addr,
   output logic        out_valid,
   output logic        out_accept
);
   filt_ctrl_t        ctrl;
   logic              ent_en;
   logic [MAC_W-1:0]  ent_addr;
   frame_class_e      cls;
   logic              addr_eq;

   rxaf_cfg_regs #(.STATION_MAC(STATION_MAC), .SEL_W(2)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .ctrl     (ctrl),
      .ent_en   (ent_en),
      .ent_addr (ent_addr)
   );

   rxaf_class_decode #(.ADDR_W(MAC_W)) u_class (
      .addr (dst_addr),
      .cls  (cls)
   );

   rxaf_addr_match #(.ADDR_W(MAC_W)) u_match (
      .a     (dst_addr),
      .b     (ent_addr),
      .equal (addr_eq)
   );

   rxaf_decide u_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .cls        (cls),
      .addr_eq    (addr_eq),
      .ctrl       (ctrl),
      .ent_en     (ent_en),
      .out_valid  (out_valid),
      .out_accept (out_accept)
   );

   AST_ENTRY_WRITE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_sel == SEL_HI |=> rd_sel != SEL_HI || rd_data == $past(wr_data)); // R10
endmodule

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;
   localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        in_valid = 1'b0;
   logic [47:0] dst_addr = '0;
   logic        out_valid;
   logic        out_accept;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic  exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   rx_addr_filter #(.STATION_MAC(MAC)) u_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .in_valid(in_valid), .dst_addr(dst_addr),
      .out_valid(out_valid), .out_accept(out_accept)
   );

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      in_valid = 1'b0;
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1'b0;
      rd_sel = sel;
      #1;
      total++;
      if (rd_data !== exp) begin
         bad++;
         $display("FAIL %s: rd sel %0d actual=%h expected=%h", tag, sel, rd_data, exp);
      end
   endtask

   // driver: one strobe per call, back-to-back when called in a row
   task automatic send(input logic [47:0] a, input logic exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1; dst_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor: compares each decision against the scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && !finished) begin
         if (out_valid) begin
            total++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL R9: out_valid without strobe actual=1 expected=0");
            end else begin
               logic  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (out_accept !== e) begin
                  bad++;
                  $display("FAIL %s: accept actual=%b expected=%b", t, out_accept, e);
               end
            end
         end else begin
            if (exp_q.size() != 0) begin
               total++; bad++;
               $display("FAIL R9: out_valid missing actual=0 expected=1");
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
            if (out_accept !== 1'b0) begin
               total++; bad++;
               $display("FAIL R9: out_accept while idle actual=%b expected=0", out_accept);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: run hung actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(2'd0, 32'h0, "R1");
      rd_chk(2'd1, 32'h0, "R1");
      rd_chk(2'd2, 32'h0211_2233, "R1");
      rd_chk(2'd3, 32'h4455_0000, "R1");

      // R5: compare disabled at reset
      send(MAC, 1'b0, "R5");
      wr(2'd0, 32'h08);
      send(MAC, 1'b0, "R5");       // enable bit 0 still clear
      // R2 only bit 0 kept
      wr(2'd1, 32'hFFFF_FFFF);
      rd_chk(2'd1, 32'h1, "R2");
      send(MAC, 1'b1, "R5");
      send(48'h02_11_22_33_44_56, 1'b0, "R5");   // last byte differs
      send(48'h03_11_22_33_44_55, 1'b0, "R3");   // group bit: multicast, take_mc off
      wr(2'd1, 32'hFFFF_FFFE);
      rd_chk(2'd1, 32'h0, "R2");
      send(MAC, 1'b0, "R2");
      wr(2'd1, 32'h1);
      wr(2'd0, 32'h00);
      send(MAC, 1'b0, "R5");

      // R7 group classes
      send(48'hFFFF_FFFF_FFFF, 1'b0, "R7");
      send(48'h01_00_5E_00_00_01, 1'b0, "R7");
      wr(2'd0, 32'h04);
      send(48'hFFFF_FFFF_FFFF, 1'b1, "R7");
      send(48'h01_00_5E_00_00_01, 1'b0, "R7");
      wr(2'd0, 32'h02);
      send(48'hFFFF_FFFF_FFFF, 1'b0, "R3");      // broadcast is not multicast
      send(48'h01_00_5E_00_00_01, 1'b1, "R7");
      send(48'hFFFF_FFFF_FFFE, 1'b1, "R3");      // not all ones: multicast

      // R4 accept all unicast
      wr(2'd0, 32'h01);
      send(48'h0A_BB_CC_DD_EE_FF, 1'b1, "R4");
      send(48'h01_00_5E_00_00_01, 1'b0, "R4");

      // R6 / R8 complement
      wr(2'd0, 32'h18);
      send(MAC, 1'b0, "R6");
      send(48'h02_11_22_33_44_56, 1'b1, "R6");
      send(48'hFFFF_FFFF_FFFF, 1'b1, "R8");
      send(48'h01_00_5E_00_00_01, 1'b1, "R8");
      wr(2'd0, 32'h10);
      send(MAC, 1'b1, "R6");                     // compare off: never matches
      wr(2'd0, 32'h19);
      send(MAC, 1'b1, "R4");

      // R10 register port
      wr(2'd0, 32'hFFFF_FFFF);
      rd_chk(2'd0, 32'h0000_001F, "R10");
      wr(2'd2, 32'hA0B1_C2D3);
      wr(2'd3, 32'hE4F5_1234);
      rd_chk(2'd2, 32'hA0B1_C2D3, "R10");
      rd_chk(2'd3, 32'hE4F5_0000, "R10");
      wr(2'd0, 32'h08);
      send(48'hA0_B1_C2_D3_E4_F5, 1'b1, "R10");
      send(MAC, 1'b0, "R10");
      send(48'hA1_B1_C2_D3_E4_F5, 1'b0, "R3");

      // R9 back-to-back strobes, then config change between strobes
      send(48'hA0_B1_C2_D3_E4_F5, 1'b1, "R9");
      send(48'hA0_B1_C2_D3_E4_F4, 1'b0, "R9");
      send(48'hA0_B1_C2_D3_E4_F5, 1'b1, "R9");
      send(48'hFFFF_FFFF_FFFF, 1'b0, "R9");
      idle(1);
      wr(2'd0, 32'h0C);
      send(48'hFFFF_FFFF_FFFF, 1'b1, "R9");
      idle(4);

      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R9: %0d decisions missing actual=%0d expected=0", exp_q.size(), exp_q.size());
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule